// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block takes a stereo pair of audio samples per frame and shifts both words, most significant bit first, onto one serial data line. A bit clock and a channel alignment clock travel with the data. Four framing conventions are selectable: I2S, left justified, right justified and a DSP-style short frame pulse. The block can be clock master or clock slave. As master it divides the system clock down to the bit clock and produces the alignment clock itself. As slave it oversamples an external bit clock and alignment clock and locks its frame position to the alignment-clock edge that opens each frame.

The serial data and the alignment clock only change where the bit clock falls, so a receiver can sample on the rising edge. A new sample pair is requested once per frame through a valid/ready handshake. When no pair is offered, the previous pair is sent again and a one-cycle underflow flag is raised.

A frame is 64 bit clocks long, split into two 32-bit halves. Each half carries one channel, except in DSP framing, where the two words are packed back to back. Control is a small state machine with two states. ST_SYNC drives the data line low and waits for a frame reference. ST_RUN shifts data. The transition SYNC_TO_RUN is taken at a bit-clock fall once a frame reference exists: always in master mode, and after a detected frame-start edge in slave mode. The transition RUN_TO_SYNC is taken whenever the master/slave select changes. The divider exponent DIV_LOG2 must be at least 1.

Top module: `audio_serial_tx`

## Requirements
- R1: In master mode bclk_o has a period of 2^(DIV_LOG2+1) clk cycles with equal high and low times, a frame is 64 bit clocks, and in the two-channel formats each alignment-clock level lasts 32 bit clocks.
- R2: sdata_o and lrclk_o change only in the clk cycle where the bit clock falls, and they hold steady through every bit-clock high phase.
- R3: With fmt_i = 0 (I2S), lrclk_o is low for the left channel and high for the right channel. Each word's MSB appears one bit clock after the alignment-clock transition.
- R4: With fmt_i = 1 (left justified), lrclk_o is high for the left channel. Each word's MSB is sent in the first bit clock of its half.
- R5: With fmt_i = 2 (right justified), lrclk_o is high for the left channel. The word's LSB is the last bit of its half, and the leading unused bits are low.
- R6: With fmt_i = 3 (DSP), the alignment clock is high only for frame bit 0. The left MSB is at bit 1, the right MSB directly follows the left LSB, and all later bits are low.
- R7: wlen_i selects the word length: 0 sends the 16 upper bits of each sample, 1 sends 20, and 2 or 3 send all 24. Slots not filled by the word are low.
- R8: s_ready is a one-cycle pulse, once per frame, in the cycle where the frame's first bit begins. The pair on s_left and s_right is taken when s_valid is high in that cycle.
- R9: If s_valid is low when s_ready pulses, the previous pair is sent again and underflow_o is high for exactly the following cycle.
- R10: With master_i = 0, bclk_o and lrclk_o stay low. Frame position follows bclk_i and lrclk_i: the falling edge of lrclk_i starts a frame for I2S, and the rising edge starts it for the other formats. Correct words are sent from the second frame after that lock. This assumes a bclk_i half period of at least 8 clk cycles and 64-bit-clock frames.
- R11: While rst_n is low, sdata_o, bclk_o, lrclk_o, s_ready and underflow_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_i | input | 1 | 1 = clock master, 0 = clock slave |
| fmt_i | input | 2 | Frame format: 0 I2S, 1 left justified, 2 right justified, 3 DSP |
| wlen_i | input | 2 | Word length: 0 = 16, 1 = 20, 2/3 = 24 bits |
| s_valid | input | 1 | Sample pair offered |
| s_left | input | SAMPLE_W | Left sample |
| s_right | input | SAMPLE_W | Right sample |
| s_ready | output | 1 | Pair accepted this cycle if s_valid |
| underflow_o | output | 1 | One-cycle flag: no pair was offered, previous pair repeated |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrclk_i | input | 1 | External alignment clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode, low in slave) |
| lrclk_o | output | 1 | Generated alignment clock (master mode, low in slave) |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
Every format is exercised in both clock modes with random 24-bit words. Full-length words separate the four bit placements, since each format starts and ends its word at a different slot. Shorter word lengths are run against right-justified and DSP framing, where a wrong length moves the word in a visible way. The corner words 800001h and 7FFFFEh check that the MSB and LSB land in exactly the right slots. Random gaps in s_valid exercise the repeat-and-flag path and show that each sent frame comes from the pair accepted at that frame's handshake.

// File: rtl/ats_pkg.sv
package ats_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_DSP = 2'd3
    } fmt_e;

    typedef enum logic {
        ST_SYNC = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

endpackage

// File: rtl/ats_clock_ctrl.sv
module ats_clock_ctrl #(
    parameter int DIV_LOG2 = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic bclk_i,
    input  logic lrclk_i,
    output logic bclk_m_o,
    output logic fall_o,
    output logic lr_up_o,
    output logic lr_dn_o
);
    localparam logic [DIV_LOG2-1:0] CNT_MAX = '1;

    logic [DIV_LOG2-1:0] cnt_q;
    logic                bclk_q;
    logic [2:0]          bsync_q;
    logic [1:0]          lsync_q;
    logic                lr_held_q;
    logic                m_fall, s_fall, s_rise;

    // master divider and slave oversampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            bclk_q    <= 1'b0;
            bsync_q   <= '0;
            lsync_q   <= '0;
            lr_held_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_MAX) begin
                bclk_q <= ~bclk_q;
            end
            bsync_q <= {bsync_q[1:0], bclk_i};
            lsync_q <= {lsync_q[0], lrclk_i};
            if (s_rise) begin
                lr_held_q <= lsync_q[1];
            end
        end
    end

    always_comb begin
        m_fall   = (cnt_q == CNT_MAX) && bclk_q;
        s_fall   = bsync_q[2] && !bsync_q[1];
        s_rise   = !bsync_q[2] && bsync_q[1];
        bclk_m_o = bclk_q;
        fall_o   = master_i ? m_fall : s_fall;
        lr_up_o  = !master_i && s_rise && lsync_q[1] && !lr_held_q;
        lr_dn_o  = !master_i && s_rise && !lsync_q[1] && lr_held_q;
    end

endmodule

// File: rtl/ats_slot_fmt.sv
module ats_slot_fmt
    import ats_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int HALF_BITS = 32
) (
    input  fmt_e                             fmt_i,
    input  logic [1:0]                       wlen_i,
    input  logic [$clog2(2*HALF_BITS)-1:0]   pos_i,
    input  logic [SAMPLE_W-1:0]              left_i,
    input  logic [SAMPLE_W-1:0]              right_i,
    output logic                             bit_o,
    output logic                             lr_o
);
    localparam int POS_W = $clog2(2*HALF_BITS);
    localparam int IDX_W = $clog2(SAMPLE_W);

    int                  len, k, j, p;
    logic                ok, half;
    logic [SAMPLE_W-1:0] word;
    logic [IDX_W-1:0]    idx;

    always_comb begin
        len  = (wlen_i == 2'd0) ? SAMPLE_W - 8 :
               (wlen_i == 2'd1) ? SAMPLE_W - 4 : SAMPLE_W;
        half = pos_i[POS_W-1];
        k    = int'(pos_i[POS_W-2:0]);
        p    = int'(pos_i);
        word = half ? right_i : left_i;
        ok   = 1'b0;
        j    = 0;
        lr_o = 1'b0;
        unique case (fmt_i)
            FMT_I2S: begin
                lr_o = half;
                ok   = (k >= 1) && (k <= len);
                j    = k - 1;
            end
            FMT_LJ: begin
                lr_o = !half;
                ok   = (k < len);
                j    = k;
            end
            FMT_RJ: begin
                lr_o = !half;
                ok   = (k >= HALF_BITS - len);
                j    = k - (HALF_BITS - len);
            end
            FMT_DSP: begin
                lr_o = (p == 0);
                if (p >= 1 && p <= len) begin
                    word = left_i;
                    j    = p - 1;
                    ok   = 1'b1;
                end else if (p > len && p <= 2 * len) begin
                    word = right_i;
                    j    = p - 1 - len;
                    ok   = 1'b1;
                end
            end
        endcase
        idx   = ok ? IDX_W'(SAMPLE_W - 1 - j) : '0;
        bit_o = ok ? word[idx] : 1'b0;
    end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
    import ats_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int HALF_BITS = 32,
    parameter int DIV_LOG2  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_i,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          wlen_i,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                s_ready,
    output logic                underflow_o,
    input  logic                bclk_i,
    input  logic                lrclk_i,
    output logic                bclk_o,
    output logic                lrclk_o,
    output logic                sdata_o
);
    localparam int FRAME_BITS = 2 * HALF_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam logic [POS_W-1:0] POS_LAST = '1;
    localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);

    state_e              state_q, state_d;
    logic [POS_W-1:0]    pos_q, pos_d;
    logic [SAMPLE_W-1:0] left_q, left_d, right_q, right_d;
    logic                sdata_q, sdata_d, lr_q, lr_d;
    logic                under_q, under_d, pend_q, pend_d, mode_q;
    logic                bclk_m, bit_fall, lr_up, lr_dn;
    logic                mode_chg, start_edge, load, bit_n, lr_n;
    fmt_e                fmt;

    assign fmt = fmt_e'(fmt_i);

    ats_clock_ctrl #(.DIV_LOG2(DIV_LOG2)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .master_i (master_i),
        .bclk_i   (bclk_i),
        .lrclk_i  (lrclk_i),
        .bclk_m_o (bclk_m),
        .fall_o   (bit_fall),
        .lr_up_o  (lr_up),
        .lr_dn_o  (lr_dn)
    );

    ats_slot_fmt #(.SAMPLE_W(SAMPLE_W), .HALF_BITS(HALF_BITS)) u_fmt (
        .fmt_i   (fmt),
        .wlen_i  (wlen_i),
        .pos_i   (pos_d),
        .left_i  (left_d),
        .right_i (right_d),
        .bit_o   (bit_n),
        .lr_o    (lr_n)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
            pos_q   <= POS_LAST;
            left_q  <= '0;
            right_q <= '0;
            sdata_q <= 1'b0;
            lr_q    <= 1'b0;
            under_q <= 1'b0;
            pend_q  <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            left_q  <= left_d;
            right_q <= right_d;
            sdata_q <= sdata_d;
            lr_q    <= lr_d;
            under_q <= under_d;
            pend_q  <= pend_d;
            mode_q  <= master_i;
        end
    end

    // transitions: SYNC_TO_RUN, RUN_TO_SYNC
    always_comb begin
        mode_chg = (master_i != mode_q);
        state_d  = state_q;
        unique case (state_q)
            ST_SYNC: if (bit_fall && (master_i || pend_q)) state_d = ST_RUN;
            ST_RUN:  if (mode_chg) state_d = ST_SYNC;
        endcase
    end

    // frame position, sample shadow and serial outputs
    always_comb begin
        start_edge = (fmt == FMT_I2S) ? lr_dn : lr_up;
        pend_d = pend_q;
        if (master_i)        pend_d = 1'b0;
        else if (start_edge) pend_d = 1'b1;
        else if (bit_fall)   pend_d = 1'b0;

        pos_d = pos_q;
        if (state_q == ST_RUN && state_d == ST_SYNC) begin
            pos_d = POS_LAST;
        end else if (bit_fall) begin
            if (!master_i && pend_q)                 pos_d = POS_ONE;
            else if (state_q == ST_RUN || master_i)  pos_d = pos_q + 1'b1;
        end

        load    = bit_fall && (state_d == ST_RUN) && (pos_d == '0);
        left_d  = (load && s_valid) ? s_left  : left_q;
        right_d = (load && s_valid) ? s_right : right_q;
        under_d = load && !s_valid;

        sdata_d = sdata_q;
        lr_d    = lr_q;
        if (state_d == ST_SYNC) begin
            sdata_d = 1'b0;
            lr_d    = 1'b0;
        end else if (bit_fall) begin
            sdata_d = bit_n;
            lr_d    = master_i && lr_n;
        end
    end

    always_comb begin
        s_ready     = load;
        underflow_o = under_q;
        sdata_o     = sdata_q;
        lrclk_o     = master_i && lr_q;
        bclk_o      = master_i && bclk_m;
    end

endmodule

// File: rtl/ats_checker.sv
module ats_checker (
    input logic clk,
    input logic rst_n,
    input logic master_i,
    input logic s_valid,
    input logic s_ready,
    input logic underflow_o,
    input logic bclk_o,
    input logic lrclk_o,
    input logic sdata_o
);
    // R2: data moves only with a bit-clock fall in master mode
    assert_data_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && $past(master_i) && !$stable(sdata_o)) |-> $fell(bclk_o));

    // R2: alignment clock moves only with a bit-clock fall
    assert_lr_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && $past(master_i) && !$stable(lrclk_o)) |-> $fell(bclk_o));

    // R8: request is a single-cycle pulse
    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    // R9: underflow lasts one cycle
    assert_underflow_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> !underflow_o);

    // R9: underflow only follows an unanswered request
    assert_underflow_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> $past(s_ready && !s_valid));
endmodule

bind audio_serial_tx ats_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_i    (master_i),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .underflow_o (underflow_o),
    .bclk_o      (bclk_o),
    .lrclk_o     (lrclk_o),
    .sdata_o     (sdata_o)
);

// File: tb/audio_serial_tx_test.sv
module audio_serial_tx_test;
    localparam int W     = 24;
    localparam int HB    = 32;
    localparam int FB    = 64;
    localparam int DIVL  = 1;
    localparam int MPER  = 2 ** (DIVL + 1);
    localparam int SHALF = 8;
    localparam int LIMIT = 180000;

    logic clk = 1'b0, rst_n = 1'b0, master_i = 1'b0;
    logic [1:0] fmt_i = 2'd0, wlen_i = 2'd2;
    logic s_valid = 1'b0;
    logic [W-1:0] s_left = '0, s_right = '0;
    logic bclk_i = 1'b0, lrclk_i = 1'b0;
    logic s_ready, underflow_o, bclk_o, lrclk_o, sdata_o;

    int  n_cmp = 0, n_bad = 0, cyc = 0;
    bit  timeout = 1'b0;

    always #4 clk = ~clk;

    audio_serial_tx #(.SAMPLE_W(W), .HALF_BITS(HB), .DIV_LOG2(DIVL)) uut (
        .clk(clk), .rst_n(rst_n), .master_i(master_i), .fmt_i(fmt_i), .wlen_i(wlen_i),
        .s_valid(s_valid), .s_left(s_left), .s_right(s_right), .s_ready(s_ready),
        .underflow_o(underflow_o), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
        .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sdata_o(sdata_o)
    );

    function automatic int word_len(input logic [1:0] wl);
        return (wl == 2'd0) ? 16 : (wl == 2'd1) ? 20 : 24;
    endfunction

    // expected data bits of one frame, index = bit-clock slot
    function automatic logic [FB-1:0] exp_frame(input logic [1:0] f, input logic [1:0] wl,
                                                input logic [W-1:0] l, input logic [W-1:0] r);
        logic [FB-1:0] v = '0;
        int n = word_len(wl);
        for (int i = 0; i < n; i++) begin
            case (f)
                2'd0: begin v[1+i] = l[W-1-i];      v[HB+1+i] = r[W-1-i]; end
                2'd1: begin v[i] = l[W-1-i];        v[HB+i] = r[W-1-i];   end
                2'd2: begin v[HB-n+i] = l[W-1-i];   v[FB-n+i] = r[W-1-i]; end
                default: begin v[1+i] = l[W-1-i];   v[1+n+i] = r[W-1-i];  end
            endcase
        end
        return v;
    endfunction

    function automatic logic [FB-1:0] exp_lr(input logic [1:0] f);
        logic [FB-1:0] v = '0;
        for (int p = 0; p < FB; p++) begin
            case (f)
                2'd0:    v[p] = (p >= HB);
                2'd3:    v[p] = (p == 0);
                default: v[p] = (p < HB);
            endcase
        end
        return v;
    endfunction

    function automatic string fmt_tag(input logic [1:0] f, input logic [1:0] wl, input bit m);
        string s;
        case (f)
            2'd0: s = "R3 I2S";
            2'd1: s = "R4 left-justified";
            2'd2: s = "R5 right-justified";
            default: s = "R6 DSP";
        endcase
        if (wl != 2'd2) s = {s, " R7 wordlen"};
        if (!m) s = {s, " R10 slave"};
        return s;
    endfunction

    task automatic check(input bit ok, input string what,
                         input logic [FB-1:0] act, input logic [FB-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic reset_dut(input bit m, input logic [1:0] f, input logic [1:0] wl);
        @(negedge clk);
        rst_n = 1'b0; master_i = m; fmt_i = f; wlen_i = wl;
        bclk_i = 1'b0; lrclk_i = 1'b0; s_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R11: everything low while in reset
        check({sdata_o, bclk_o, lrclk_o, s_ready, underflow_o} == 5'b0,
              "R11 reset outputs", FB'({sdata_o, bclk_o, lrclk_o, s_ready, underflow_o}), '0);
        rst_n = 1'b1;
    endtask

    task automatic new_stim(input bit corner);
        if (corner) begin
            s_valid = 1'b1; s_left = 24'h800001; s_right = 24'h7FFFFE;
        end else begin
            s_valid = (($urandom % 4) != 0);
            s_left  = W'($urandom);
            s_right = W'($urandom);
        end
    endtask

    task automatic run_cfg(input bit m, input logic [1:0] f, input logic [1:0] wl,
                           input int nframes, input bit corner);
        logic [FB-1:0] lrpat, cb, cl;
        logic [W-1:0]  el, er, fl, fr;
        logic          prev_b, prev_lr, hold_d, hold_l, cur_d, cur_l;
        bit            synced, got, refresh, uf_pend, uf_exp, r2_bad, quiet_bad;
        int            bpos, frame_idx, rdy_cnt, since_rise, last_period, sc, done;
        string         tag;
        if (timeout) return;
        reset_dut(m, f, wl);
        lrpat = exp_lr(f); tag = fmt_tag(f, wl, m);
        cb = '0; cl = '0; el = '0; er = '0; fl = '0; fr = '0;
        prev_b = 1'b0; prev_lr = 1'b0; hold_d = 1'b0; hold_l = 1'b0; cur_d = 1'b0; cur_l = 1'b0;
        synced = !m; refresh = 1'b0; uf_pend = 1'b0; uf_exp = 1'b0; r2_bad = 1'b0; quiet_bad = 1'b0;
        bpos = FB - 1; frame_idx = -1; rdy_cnt = 0; since_rise = 0; last_period = 0; sc = 0; done = 0;
        new_stim(corner);
        while (done < nframes) begin
            @(negedge clk);
            cyc++;
            if (cyc > LIMIT) begin
                timeout = 1'b1; n_cmp++; n_bad++;
                $display("FAIL watchdog (all requirements) actual=%0d expected<=%0d", cyc, LIMIT);
                break;
            end
            if (refresh) begin new_stim(corner); refresh = 1'b0; end
            if (uf_pend) begin
                check(underflow_o == uf_exp, "R9 underflow flag", FB'(underflow_o), FB'(uf_exp));
                uf_pend = 1'b0;
            end
            if (s_ready) begin
                rdy_cnt++; uf_pend = 1'b1; uf_exp = !s_valid; refresh = 1'b1;
                if (s_valid) begin el = s_left; er = s_right; end
            end
            got = 1'b0;
            if (m) begin
                since_rise++;
                if (bclk_o && prev_b && (sdata_o !== hold_d || lrclk_o !== hold_l)) r2_bad = 1'b1;
                if (bclk_o && !prev_b) begin
                    last_period = since_rise; since_rise = 0;
                    hold_d = sdata_o; hold_l = lrclk_o; cur_d = sdata_o; cur_l = lrclk_o; got = 1'b1;
                end
                prev_b = bclk_o;
            end else begin
                if (bclk_o || lrclk_o) quiet_bad = 1'b1;
                sc++;
                if (sc == SHALF) begin
                    cur_d = sdata_o; cur_l = lrclk_o; got = 1'b1; bclk_i = 1'b1;
                end else if (sc == 2 * SHALF) begin
                    sc = 0; bpos = (bpos + 1) % FB; lrclk_i = lrpat[bpos]; bclk_i = 1'b0;
                end
            end
            if (got) begin
                if (m) begin
                    if (synced) bpos = (bpos + 1) % FB;
                    else if ((f == 2'd0) ? (prev_lr && !cur_l) : (!prev_lr && cur_l)) begin
                        synced = 1'b1; bpos = 0;
                    end
                    prev_lr = cur_l;
                end
                if (synced) begin
                    if (bpos == 0) begin
                        if (frame_idx >= 2) begin
                            check(cb == exp_frame(f, wl, fl, fr), {tag, " data"}, cb, exp_frame(f, wl, fl, fr));
                            check(rdy_cnt == 1, "R8 one request per frame", FB'(rdy_cnt), FB'(1));
                            if (m) begin
                                check(cl == lrpat, {tag, " R1 alignment clock"}, cl, lrpat);
                                check(last_period == MPER, "R1 bit clock period", FB'(last_period), FB'(MPER));
                                check(!r2_bad, "R2 stable in high phase", FB'(r2_bad), '0);
                            end else begin
                                check(!quiet_bad, "R10 clock outputs low", FB'(quiet_bad), '0);
                            end
                            done++;
                        end
                        r2_bad = 1'b0; quiet_bad = 1'b0; rdy_cnt = 0;
                        frame_idx++; fl = el; fr = er;
                    end
                    cb[bpos] = cur_d; cl[bpos] = cur_l;
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7531));
        // directed: every format in both modes, full word length
        for (int f = 0; f < 4; f++) run_cfg(1'b1, 2'(f), 2'd2, 5, 1'b0);
        for (int f = 0; f < 4; f++) run_cfg(1'b0, 2'(f), 2'd2, 3, 1'b0);
        // corner words and short word lengths
        run_cfg(1'b1, 2'd2, 2'd0, 4, 1'b1);
        run_cfg(1'b1, 2'd3, 2'd1, 4, 1'b1);
        run_cfg(1'b1, 2'd0, 2'd3, 3, 1'b1);
        run_cfg(1'b0, 2'd1, 2'd0, 3, 1'b1);
        // random configurations
        for (int i = 0; i < 6; i++)
            run_cfg(1'(($urandom % 3) != 0), 2'($urandom % 4), 2'($urandom % 4), 3, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule